// File: doc/BRIEF.md
# Multi-Waveform Chirp Sequencer

The sequencer runs the transmit timeline of a radar frame. A frame is built from up to three sub-frames. Each sub-frame uses one waveform, in the order short, medium, long. Within a sub-frame the block emits a programmable number of chirps. Every chirp is a transmit window followed by a listen window. Both window lengths are counted in clock cycles and are set separately for each waveform, so the pulse repetition interval differs between sub-frames. A 3-bit mask selects which sub-frames take part.

Downstream logic uses the outputs directly. The waveform selector and sub-frame index tell it which waveform is in use. The chirp-active level marks the transmit window. A one-cycle start pulse opens each chirp, and a one-cycle done pulse closes the frame. All configuration inputs are captured when a frame starts, so the host may rewrite them at any time.

Top module: `chirp_seq_top`

## Requirements
- R1: `wave_sel_o` and `sf_idx_o` encode short = 2'b00, medium = 2'b01 and long = 2'b10. 2'b11 never appears. The selector changes only at the first transmit cycle of a chirp.
- R2: Enabled sub-frames run in the order short, medium, long. Each one emits `chirps_per_sf_i` chirps, with `chirp_idx_o` counting 0 to N-1 inside the sub-frame.
- R3: Mask bit 0 enables short, bit 1 enables medium and bit 2 enables long. A disabled sub-frame is skipped: the first chirp of the next enabled sub-frame starts in the cycle right after the previous listen window.
- R4: With all mask bits clear, no frame starts and `chirp_active_o` stays low.
- R5: `chirp_active_o` is high for exactly the transmit length of the current waveform, then low for exactly its listen length.
- R6: `chirp_start_o` is high for one cycle, in the first transmit cycle of every chirp, and at no other time.
- R7: `frame_done_o` pulses for one cycle, in the cycle after the last listen window of the last enabled sub-frame. If `enable_i` is still high, the next frame's first transmit cycle follows immediately.
- R8: The mask, the six lengths and the chirp count are sampled when a frame starts. Changing them during a frame has no effect until the next frame.
- R9: A length or chirp count of zero behaves as one.
- R10: While in reset and after reset, the outputs are idle: active, start and done are low, and the selector, sub-frame index and chirp index are zero.
- R11: A frame starts only when `enable_i` is high at an idle cycle. Lowering `enable_i` during a frame lets the frame run to its done pulse, after which the block stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock (100 MHz cycles count windows) |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Allows a new frame to start |
| sf_mask_i | input | 3 | Sub-frame enable: bit 0 short, bit 1 medium, bit 2 long |
| short_tx_len_i | input | LEN_W | Short transmit window, cycles |
| short_rx_len_i | input | LEN_W | Short listen window, cycles |
| med_tx_len_i | input | LEN_W | Medium transmit window, cycles |
| med_rx_len_i | input | LEN_W | Medium listen window, cycles |
| long_tx_len_i | input | LEN_W | Long transmit window, cycles |
| long_rx_len_i | input | LEN_W | Long listen window, cycles |
| chirps_per_sf_i | input | NUM_W | Chirps per sub-frame |
| wave_sel_o | output | 2 | Current waveform |
| chirp_active_o | output | 1 | High during the transmit window |
| chirp_start_o | output | 1 | One-cycle pulse opening a chirp |
| sf_idx_o | output | 2 | Current sub-frame index |
| chirp_idx_o | output | NUM_W | Chirp index within the sub-frame |
| frame_done_o | output | 1 | One-cycle pulse closing a frame |

## Verification
The most delicate coincidences involve the last cycle of a listen window. In that same cycle the block may change sub-frame, skip a disabled one and decide the frame is over, so the start of the next chirp, the waveform switch and the done pulse are closely packed. The bench provokes this with sparse masks and with zero lengths and counts, which make every window one cycle long. It then compares each cycle against a model that walks the enabled sub-frames in order. It also holds enable high across the done pulse and checks that the next frame's first start pulse lands in the very next cycle. Finally, it rewrites the configuration in the first transmit cycle of a frame and checks that the frame already running does not change.

// File: rtl/chirp_seq_pkg.sv
package chirp_seq_pkg;
  localparam int unsigned NUM_SF = 3;
  localparam int unsigned SF_W   = 2;

  typedef enum logic [1:0] {
    WAVE_SHORT  = 2'b00,
    WAVE_MEDIUM = 2'b01,
    WAVE_LONG   = 2'b10
  } wave_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_TX   = 2'b01,
    ST_RX   = 2'b10
  } seq_st_e;
endpackage

// File: rtl/chirp_cfg_snap.sv
module chirp_cfg_snap
  import chirp_seq_pkg::*;
#(
  parameter int unsigned LEN_W = 16,
  parameter int unsigned NUM_W = 6
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          take_i,
  input  logic [NUM_SF-1:0]             mask_i,
  input  logic [NUM_SF-1:0][LEN_W-1:0]  tx_len_i,
  input  logic [NUM_SF-1:0][LEN_W-1:0]  rx_len_i,
  input  logic [NUM_W-1:0]              num_i,
  output logic [NUM_SF-1:0]             mask_o,
  output logic [NUM_SF-1:0][LEN_W-1:0]  tx_len_o,
  output logic [NUM_SF-1:0][LEN_W-1:0]  rx_len_o,
  output logic [NUM_W-1:0]              num_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_o   <= '0;
      tx_len_o <= '0;
      rx_len_o <= '0;
      num_o    <= '0;
    end else if (take_i) begin
      mask_o   <= mask_i;
      tx_len_o <= tx_len_i;
      rx_len_o <= rx_len_i;
      num_o    <= num_i;
    end
  end
endmodule

// File: rtl/chirp_sf_pick.sv
module chirp_sf_pick
  import chirp_seq_pkg::*;
(
  input  logic [NUM_SF-1:0] mask_i,
  input  logic [SF_W-1:0]   from_i,
  output logic              found_o,
  output logic [SF_W-1:0]   idx_o
);
  // lowest enabled index at or above from_i
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = NUM_SF - 1; i >= 0; i--) begin
      if (mask_i[i] && (i >= int'(from_i))) begin
        found_o = 1'b1;
        idx_o   = SF_W'(i);
      end
    end
  end
endmodule

// File: rtl/chirp_win_timer.sv
module chirp_win_timer #(
  parameter int unsigned LEN_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             last_o
);
  logic [LEN_W-1:0] cnt_q;
  logic [LEN_W-1:0] len_m1;

  // zero length saturates to one cycle
  assign len_m1 = (len_i == '0) ? '0 : len_i - LEN_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= len_m1;
    else if (cnt_q != '0)   cnt_q <= cnt_q - LEN_W'(1);
  end

  assign last_o = (cnt_q == '0);
endmodule

// File: rtl/chirp_seq_top.sv
module chirp_seq_top
  import chirp_seq_pkg::*;
#(
  parameter int unsigned LEN_W = 16,
  parameter int unsigned NUM_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic [2:0]       sf_mask_i,
  input  logic [LEN_W-1:0] short_tx_len_i,
  input  logic [LEN_W-1:0] short_rx_len_i,
  input  logic [LEN_W-1:0] med_tx_len_i,
  input  logic [LEN_W-1:0] med_rx_len_i,
  input  logic [LEN_W-1:0] long_tx_len_i,
  input  logic [LEN_W-1:0] long_rx_len_i,
  input  logic [NUM_W-1:0] chirps_per_sf_i,
  output logic [1:0]       wave_sel_o,
  output logic             chirp_active_o,
  output logic             chirp_start_o,
  output logic [1:0]       sf_idx_o,
  output logic [NUM_W-1:0] chirp_idx_o,
  output logic             frame_done_o
);
  logic [NUM_SF-1:0][LEN_W-1:0] tx_live, rx_live, tx_cfg, rx_cfg;
  logic [NUM_SF-1:0]            mask_cfg;
  logic [NUM_W-1:0]             num_cfg, last_idx;

  assign tx_live = {long_tx_len_i, med_tx_len_i, short_tx_len_i};
  assign rx_live = {long_rx_len_i, med_rx_len_i, short_rx_len_i};

  seq_st_e          st_q, st_d;
  wave_e            sf_q, sf_d;
  logic [NUM_W-1:0] chirp_q, chirp_d;
  logic             start_q, start_d, done_q, done_d;
  logic             go, tmr_load, tmr_last;
  logic [LEN_W-1:0] tmr_len;
  logic             first_found, next_found;
  logic [SF_W-1:0]  first_idx, next_idx, next_from;

  assign go = (st_q == ST_IDLE) && enable_i && first_found;

  chirp_cfg_snap #(.LEN_W(LEN_W), .NUM_W(NUM_W)) i_snap (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .take_i   (go),
    .mask_i   (sf_mask_i),
    .tx_len_i (tx_live),
    .rx_len_i (rx_live),
    .num_i    (chirps_per_sf_i),
    .mask_o   (mask_cfg),
    .tx_len_o (tx_cfg),
    .rx_len_o (rx_cfg),
    .num_o    (num_cfg)
  );

  chirp_sf_pick i_pick_first (
    .mask_i  (sf_mask_i),
    .from_i  ('0),
    .found_o (first_found),
    .idx_o   (first_idx)
  );

  assign next_from = SF_W'(sf_q) + SF_W'(1);

  chirp_sf_pick i_pick_next (
    .mask_i  (mask_cfg),
    .from_i  (next_from),
    .found_o (next_found),
    .idx_o   (next_idx)
  );

  chirp_win_timer #(.LEN_W(LEN_W)) i_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tmr_load),
    .len_i  (tmr_len),
    .last_o (tmr_last)
  );

  // zero chirp count saturates to one
  assign last_idx = (num_cfg == '0) ? '0 : num_cfg - NUM_W'(1);

  always_comb begin
    st_d     = st_q;
    sf_d     = sf_q;
    chirp_d  = chirp_q;
    start_d  = 1'b0;
    done_d   = 1'b0;
    tmr_load = 1'b0;
    tmr_len  = '0;
    unique case (st_q)
      ST_IDLE: if (go) begin
        st_d     = ST_TX;
        sf_d     = wave_e'(first_idx);
        chirp_d  = '0;
        start_d  = 1'b1;
        tmr_load = 1'b1;
        tmr_len  = tx_live[first_idx];
      end
      ST_TX: if (tmr_last) begin
        st_d     = ST_RX;
        tmr_load = 1'b1;
        tmr_len  = rx_cfg[sf_q];
      end
      ST_RX: if (tmr_last) begin
        if (chirp_q != last_idx) begin
          st_d     = ST_TX;
          chirp_d  = chirp_q + NUM_W'(1);
          start_d  = 1'b1;
          tmr_load = 1'b1;
          tmr_len  = tx_cfg[sf_q];
        end else if (next_found) begin
          st_d     = ST_TX;
          sf_d     = wave_e'(next_idx);
          chirp_d  = '0;
          start_d  = 1'b1;
          tmr_load = 1'b1;
          tmr_len  = tx_cfg[next_idx];
        end else begin
          st_d   = ST_IDLE;
          done_d = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      sf_q    <= WAVE_SHORT;
      chirp_q <= '0;
      start_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      sf_q    <= sf_d;
      chirp_q <= chirp_d;
      start_q <= start_d;
      done_q  <= done_d;
    end
  end

  assign wave_sel_o     = sf_q;
  assign sf_idx_o       = sf_q;
  assign chirp_idx_o    = chirp_q;
  assign chirp_active_o = (st_q == ST_TX);
  assign chirp_start_o  = start_q;
  assign frame_done_o   = done_q;
endmodule

// File: rtl/chirp_seq_chk.sv
module chirp_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] wave_sel_o,
  input logic       chirp_active_o,
  input logic       chirp_start_o,
  input logic       frame_done_o
);
  AST_WAVE_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wave_sel_o != 2'b11); // R1
  AST_WAVE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chirp_active_o && !chirp_start_o) |-> $stable(wave_sel_o)); // R1
  AST_START_IN_TX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chirp_start_o |-> chirp_active_o); // R6
  AST_START_ON_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(chirp_active_o) |-> chirp_start_o); // R6
  AST_START_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chirp_start_o |=> !chirp_start_o); // R6
  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_o |=> !frame_done_o); // R7
  AST_DONE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_o |-> (!chirp_active_o && !$past(chirp_active_o))); // R7
endmodule

bind chirp_seq_top chirp_seq_chk i_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .wave_sel_o     (wave_sel_o),
  .chirp_active_o (chirp_active_o),
  .chirp_start_o  (chirp_start_o),
  .frame_done_o   (frame_done_o)
);

// File: tb/test_chirp_seq_top.sv
module test_chirp_seq_top;
  typedef struct packed {
    logic [2:0] mask;
    logic [7:0] txs, rxs, txm, rxm, txl, rxl;
    logic [5:0] n;
  } vec_t;

  // R2 R3 R5 R9 patterns
  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{3'b111, 8'd2, 8'd3, 8'd3, 8'd2, 8'd4, 8'd5, 6'd2},
    '{3'b101, 8'd1, 8'd2, 8'd9, 8'd9, 8'd3, 8'd1, 6'd3},
    '{3'b010, 8'd4, 8'd1, 8'd2, 8'd3, 8'd1, 8'd1, 6'd3},
    '{3'b110, 8'd3, 8'd3, 8'd0, 8'd0, 8'd2, 8'd0, 6'd1},
    '{3'b001, 8'd0, 8'd2, 8'd5, 8'd5, 8'd5, 8'd5, 6'd0},
    '{3'b100, 8'd7, 8'd7, 8'd7, 8'd7, 8'd6, 8'd4, 6'd1}
  };

  logic        clk = 1'b0, rst_n = 1'b0, en = 1'b0;
  logic [2:0]  mask = '0;
  logic [15:0] txs = '0, rxs = '0, txm = '0, rxm = '0, txl = '0, rxl = '0;
  logic [5:0]  nch = '0;
  logic [1:0]  wave, sfi;
  logic        act, start, done;
  logic [5:0]  cidx;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  chirp_seq_top i_chirp_seq_top (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(en), .sf_mask_i(mask),
    .short_tx_len_i(txs), .short_rx_len_i(rxs), .med_tx_len_i(txm),
    .med_rx_len_i(rxm), .long_tx_len_i(txl), .long_rx_len_i(rxl),
    .chirps_per_sf_i(nch), .wave_sel_o(wave), .chirp_active_o(act),
    .chirp_start_o(start), .sf_idx_o(sfi), .chirp_idx_o(cidx),
    .frame_done_o(done)
  );

  task automatic chk(input bit ok, input string req, input int act_v, input int exp_v);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act_v, exp_v);
    end
  endtask

  function automatic int sat1(input int x);
    return (x == 0) ? 1 : x;
  endfunction

  function automatic int len_of(input vec_t v, input int s, input bit rx);
    case (s)
      0: return sat1(int'(rx ? v.rxs : v.txs));
      1: return sat1(int'(rx ? v.rxm : v.txm));
      default: return sat1(int'(rx ? v.rxl : v.txl));
    endcase
  endfunction

  task automatic drive(input vec_t v);
    mask = v.mask; nch = v.n;
    txs = 16'(v.txs); rxs = 16'(v.rxs); txm = 16'(v.txm);
    rxm = 16'(v.rxm); txl = 16'(v.txl); rxl = 16'(v.rxl);
  endtask

  // called at a negedge with the block idle; checks every cycle of one frame
  task automatic run_frame(input vec_t v, input bit mutate, input bit keep_en, input string req);
    bit first = 1'b1;
    drive(v);
    en = 1'b1;
    for (int s = 0; s < 3; s++) begin
      if (v.mask[s]) begin
        for (int c = 0; c < sat1(int'(v.n)); c++) begin
          int bad = 0;
          for (int t = 0; t < len_of(v, s, 1'b0); t++) begin
            @(negedge clk);
            if (!act || start != (t == 0) || wave != 2'(s) || sfi != 2'(s) ||
                cidx != 6'(c) || done) bad++;
            if (first && mutate) begin
              mask = 3'b111; nch = 6'd5;
              txs = 16'd9; rxs = 16'd9; txm = 16'd9;
              rxm = 16'd9; txl = 16'd9; rxl = 16'd9;
            end
            first = 1'b0;
          end
          for (int t = 0; t < len_of(v, s, 1'b1); t++) begin
            @(negedge clk);
            if (act || start || done || wave != 2'(s) || cidx != 6'(c)) bad++;
          end
          chk(bad == 0, req, bad, 0);
        end
      end
    end
    @(negedge clk);
    chk(done && !act, {req, " R7 done pulse"}, int'(done), 1);
    if (!keep_en) en = 1'b0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog: actual 1 expected 0");
    checks++; fails++;
    finish_run();
  end

  initial begin
    int n_act;
    bit seen;
    // R10 reset state
    repeat (3) @(negedge clk);
    chk(!act && !start && !done && wave == 2'b00 && sfi == 2'b00 && cidx == 0,
        "R10 in reset", int'(act), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!act && !start && !done && wave == 2'b00 && cidx == 0,
        "R10 after reset", int'(act), 0);

    // R11 disabled: nothing starts
    drive(VECS[0]);
    n_act = 0;
    repeat (40) begin @(negedge clk); if (act || start) n_act++; end
    chk(n_act == 0, "R11 enable low", n_act, 0);

    // R4 empty mask
    mask = 3'b000; en = 1'b1;
    n_act = 0;
    repeat (40) begin @(negedge clk); if (act || start || done) n_act++; end
    chk(n_act == 0, "R4 empty mask", n_act, 0);
    en = 1'b0;
    @(negedge clk);

    // table walk: R1 R2 R3 R5 R6 R9
    for (int i = 0; i < NV; i++)
      run_frame(VECS[i], 1'b0, 1'b0, "R1 R2 R3 R5 R6 R9 sequence");
    @(negedge clk);

    // R8 mid-frame rewrite ignored
    run_frame(VECS[1], 1'b1, 1'b0, "R8 snapshot");
    @(negedge clk);

    // R7 back-to-back frames, then R11 enable drop mid-frame
    run_frame(VECS[0], 1'b0, 1'b1, "R7 first frame");
    @(negedge clk);
    chk(act && start && wave == 2'b00 && cidx == 0, "R7 next frame starts at once",
        int'(start), 1);
    en = 1'b0;
    seen = 1'b0;
    for (int k = 0; k < 300 && !seen; k++) begin
      @(negedge clk);
      if (done) seen = 1'b1;
    end
    chk(seen, "R11 frame completes after enable drop", int'(seen), 1);
    n_act = 0;
    repeat (30) begin @(negedge clk); if (act || start) n_act++; end
    chk(n_act == 0, "R11 idle after completion", n_act, 0);

    finish_run();
  end
endmodule